// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves one translation-buffer miss. It takes a virtual page number, the kind of access that missed, and the table base address of the running process. It computes where the page table entry lives, fetches it with a single read on a valid/ready memory port, and inspects the entry. It then returns either the physical page number and management bits, ready to refill the translation buffer, or a fault that names the virtual page and its cause.

The table is flat: entry *n* describes virtual page *n*, and each entry occupies one 64-bit word. Only one walk is in flight at a time. The walker passes through named states:

- **IDLE**: accepts a request. IDLE→ISSUE on `req_valid`.
- **ISSUE**: drives the read. ISSUE→WAIT when `mem_req_ready` is high.
- **WAIT**: accepts the returned entry. WAIT→CHECK on `mem_rsp_valid`.
- **CHECK**: decodes the entry. CHECK→DONE when the access is allowed, CHECK→FAULT otherwise.
- **DONE/FAULT**: present the result. Each returns to IDLE on `res_ready`.

Top module: `ptw_walker`

## Requirements
- R1: After reset, or when reset is applied in the middle of a walk, `busy`=0, `req_ready`=1, `mem_req_valid`=0, `mem_rsp_ready`=0 and `res_valid`=0.
- R2: The read address is `table_base + vpn*8`, truncated to the address width. Both `table_base` and `vpn` are sampled when the request is accepted.
- R3: Each walk issues exactly one read. While `mem_req_ready` is low, `mem_req_valid` stays high and the address does not change.
- R4: `busy` is high from the cycle after acceptance until the result is consumed. `req_ready` is low during that time, and a request presented then has no effect on the walk in progress.
- R5: If entry bit 0 (present) is 0, the result is a fault with cause 2'b01 (not present), whatever the rights field holds.
- R6: The entry layout is: bit 0 present, bits [2:1] rights, bit 3 dirty, bit 4 referenced, physical page number in bits [29:8]. All other bits are ignored. A successful walk returns these fields with `res_fault`=0 and cause 2'b00.
- R7: Access kind codes are 00 load, 01 store and 10 fetch. Rights codes are 00 read-only, 01 read/write and 10 executable. A load is allowed on 00, 01 and 10. A store is allowed only on 01. A fetch is allowed only on 10. A disallowed access on a present entry faults with cause 2'b10 (protection).
- R8: Rights code 11 and access kind 11 always give a protection fault when the entry is present.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid` and all result fields hold steady.
- R10: A fault result carries the requesting VPN and drives the page number, rights, dirty and referenced outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vpn | input | 26 | Virtual page number that missed |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| table_base | input | 36 | Page table base address of the current process |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 36 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_ready | output | 1 | Walker awaiting entry data |
| mem_rsp_data | input | 64 | Entry word |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumed |
| res_fault | output | 1 | Result is a fault |
| res_cause | output | 2 | 00 none, 01 not present, 10 protection |
| res_vpn | output | 26 | VPN of the walk |
| res_ppn | output | 22 | Physical page number for the refill |
| res_rights | output | 2 | Rights code for the refill |
| res_dirty | output | 1 | Dirty bit for the refill |
| res_ref | output | 1 | Referenced bit for the refill |
| busy | output | 1 | Walk in progress |

## Verification
The bench builds the walker with its default parameters: a 26-bit VPN, a 22-bit PPN, a 36-bit physical address and 8-byte entries. With these values, an all-ones VPN added to a base near the top of the address space shows that the address truncates. A 22-bit page number of all ones fills its field right up to bit 29, and the unused entry bits can be loaded with ones to show they are ignored. Every pairing of the three access kinds with the four rights codes that matters is reached, present and not present. Delayed memory handshakes, a stalled result consumer and a request presented while busy are also exercised.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_CHECK,
        S_DONE,
        S_FAULT
    } walk_state_e;

    localparam logic [1:0] CAUSE_NONE   = 2'b00;
    localparam logic [1:0] CAUSE_ABSENT = 2'b01;
    localparam logic [1:0] CAUSE_PROT   = 2'b10;

    localparam logic [1:0] KIND_LOAD  = 2'b00;
    localparam logic [1:0] KIND_STORE = 2'b01;
    localparam logic [1:0] KIND_FETCH = 2'b10;

    localparam logic [1:0] RIGHTS_RO   = 2'b00;
    localparam logic [1:0] RIGHTS_RW   = 2'b01;
    localparam logic [1:0] RIGHTS_EXEC = 2'b10;
    localparam logic [1:0] RIGHTS_RSVD = 2'b11;

    localparam int PRESENT_BIT = 0;
    localparam int RIGHTS_LSB  = 1;
    localparam int DIRTY_BIT   = 3;
    localparam int REF_BIT     = 4;
    localparam int PPN_LSB     = 8;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int ADDR_W      = 36,
    parameter int VPN_W       = 26,
    parameter int ENTRY_BYTES = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VPN_W-1:0]  vpn,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int SHIFT = $clog2(ENTRY_BYTES);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset     = ADDR_W'(vpn) << SHIFT;
        entry_addr = base + offset;
    end
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PPN_W  = 22
) (
    input  logic [DATA_W-1:0] entry,
    input  logic [1:0]        kind,
    output logic              allowed,
    output logic [1:0]        cause,
    output logic [PPN_W-1:0]  ppn,
    output logic [1:0]        rights,
    output logic              dirty,
    output logic              refd
);
    localparam logic [DATA_W-1:0] PPN_MASK   = ((DATA_W'(1) << PPN_W) - DATA_W'(1)) << PPN_LSB;
    localparam logic [DATA_W-1:0] FIELD_MASK = PPN_MASK | DATA_W'(5'h1F);

    logic present;
    logic permit;
    logic unused_spare_bits;

    assign unused_spare_bits = ^(entry & ~FIELD_MASK);

    always_comb begin
        present = entry[PRESENT_BIT];
        rights  = entry[RIGHTS_LSB +: 2];
        dirty   = entry[DIRTY_BIT];
        refd    = entry[REF_BIT];
        ppn     = entry[PPN_LSB +: PPN_W];

        unique case (kind)
            KIND_LOAD:  permit = (rights != RIGHTS_RSVD);
            KIND_STORE: permit = (rights == RIGHTS_RW);
            KIND_FETCH: permit = (rights == RIGHTS_EXEC);
            default:    permit = 1'b0;
        endcase

        if (!present)     cause = CAUSE_ABSENT;
        else if (!permit) cause = CAUSE_PROT;
        else              cause = CAUSE_NONE;

        allowed = present && permit;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VPN_W       = 26,
    parameter int PPN_W       = 22,
    parameter int ADDR_W      = 36,
    parameter int DATA_W      = 64,
    parameter int ENTRY_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] table_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic              res_fault,
    output logic [1:0]        res_cause,
    output logic [VPN_W-1:0]  res_vpn,
    output logic [PPN_W-1:0]  res_ppn,
    output logic [1:0]        res_rights,
    output logic              res_dirty,
    output logic              res_ref,
    output logic              busy
);
    walk_state_e state_q, state_d;

    logic [VPN_W-1:0]  vpn_q;
    logic [1:0]        kind_q;
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] entry_q;

    logic [1:0]        cause_q;
    logic [PPN_W-1:0]  ppn_q;
    logic [1:0]        rights_q;
    logic              dirty_q;
    logic              ref_q;

    logic              chk_allowed;
    logic [1:0]        chk_cause;
    logic [PPN_W-1:0]  chk_ppn;
    logic [1:0]        chk_rights;
    logic              chk_dirty;
    logic              chk_ref;

    ptw_addr_gen #(
        .ADDR_W      (ADDR_W),
        .VPN_W       (VPN_W),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) i_addr_gen (
        .base       (base_q),
        .vpn        (vpn_q),
        .entry_addr (mem_req_addr)
    );

    ptw_entry_check #(
        .DATA_W (DATA_W),
        .PPN_W  (PPN_W)
    ) i_entry_check (
        .entry   (entry_q),
        .kind    (kind_q),
        .allowed (chk_allowed),
        .cause   (chk_cause),
        .ppn     (chk_ppn),
        .rights  (chk_rights),
        .dirty   (chk_dirty),
        .refd    (chk_ref)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid)     state_d = S_ISSUE;
            S_ISSUE: if (mem_req_ready) state_d = S_WAIT;
            S_WAIT:  if (mem_rsp_valid) state_d = S_CHECK;
            S_CHECK: state_d = chk_allowed ? S_DONE : S_FAULT;
            S_DONE:  if (res_ready)     state_d = S_IDLE;
            S_FAULT: if (res_ready)     state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Captured request, entry and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q    <= '0;
            kind_q   <= '0;
            base_q   <= '0;
            entry_q  <= '0;
            cause_q  <= CAUSE_NONE;
            ppn_q    <= '0;
            rights_q <= '0;
            dirty_q  <= 1'b0;
            ref_q    <= 1'b0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                vpn_q  <= req_vpn;
                kind_q <= req_kind;
                base_q <= table_base;
            end
            if (state_q == S_WAIT && mem_rsp_valid) begin
                entry_q <= mem_rsp_data;
            end
            if (state_q == S_CHECK) begin
                cause_q  <= chk_cause;
                ppn_q    <= chk_allowed ? chk_ppn    : '0;
                rights_q <= chk_allowed ? chk_rights : '0;
                dirty_q  <= chk_allowed && chk_dirty;
                ref_q    <= chk_allowed && chk_ref;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_rsp_ready = 1'b0;
        res_valid     = 1'b0;
        res_fault     = 1'b0;
        unique case (state_q)
            S_IDLE:  req_ready     = 1'b1;
            S_ISSUE: mem_req_valid = 1'b1;
            S_WAIT:  mem_rsp_ready = 1'b1;
            S_CHECK: ;
            S_DONE:  res_valid     = 1'b1;
            S_FAULT: begin
                res_valid = 1'b1;
                res_fault = 1'b1;
            end
            default: ;
        endcase
        busy       = (state_q != S_IDLE);
        res_cause  = cause_q;
        res_vpn    = vpn_q;
        res_ppn    = ppn_q;
        res_rights = rights_q;
        res_dirty  = dirty_q;
        res_ref    = ref_q;
    end

    // R3: the read holds steady until memory takes it
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R3: a taken read is followed by no second read before the response
    p_single_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    // R4: acceptance raises busy
    p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> busy);

    // R4: request port closed while busy
    p_busy_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    // R9: result held until consumed
    p_res_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid &&
            $stable({res_fault, res_cause, res_vpn, res_ppn, res_rights, res_dirty, res_ref}));

    // R5/R6: fault flag agrees with the cause code
    p_cause_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_fault == (res_cause != CAUSE_NONE)));

    // R10: fault results carry no refill fields
    p_fault_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault |-> (res_ppn == '0) && (res_rights == 2'b00) && !res_dirty && !res_ref);

endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [35:0] base;
        logic [25:0] vpn;
        logic [1:0]  kind;
        logic        v;
        logic [1:0]  rights;
        logic        d;
        logic        r;
        logic [21:0] ppn;
        logic        fault;
        logic [1:0]  cause;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{36'h0_0010_0000, 26'h0000001, 2'b00, 1'b1, 2'b01, 1'b0, 1'b1, 22'h000ABC, 1'b0, 2'b00},
        '{36'h0_0020_0000, 26'h0001234, 2'b01, 1'b1, 2'b01, 1'b1, 1'b1, 22'h3FFFFF, 1'b0, 2'b00},
        '{36'h0_0020_0000, 26'h0001235, 2'b01, 1'b1, 2'b00, 1'b0, 1'b1, 22'h000111, 1'b1, 2'b10},
        '{36'h1_0000_0000, 26'h2000000, 2'b10, 1'b1, 2'b10, 1'b0, 1'b0, 22'h155555, 1'b0, 2'b00},
        '{36'h1_0000_0000, 26'h2000001, 2'b10, 1'b1, 2'b01, 1'b1, 1'b0, 22'h000222, 1'b1, 2'b10},
        '{36'h0_4000_0008, 26'h0000100, 2'b00, 1'b1, 2'b10, 1'b0, 1'b1, 22'h2AAAAA, 1'b0, 2'b00},
        '{36'h0_4000_0000, 26'h0000101, 2'b00, 1'b0, 2'b01, 1'b1, 1'b1, 22'h000333, 1'b1, 2'b01},
        '{36'h0_4000_0000, 26'h0000102, 2'b01, 1'b0, 2'b11, 1'b0, 1'b0, 22'h000444, 1'b1, 2'b01},
        '{36'h0_5000_0000, 26'h0000200, 2'b00, 1'b1, 2'b11, 1'b0, 1'b1, 22'h000555, 1'b1, 2'b10},
        '{36'h0_5000_0000, 26'h0000201, 2'b11, 1'b1, 2'b01, 1'b1, 1'b1, 22'h000666, 1'b1, 2'b10},
        '{36'hF_FFFF_FFF8, 26'h3FFFFFF, 2'b00, 1'b1, 2'b00, 1'b0, 1'b0, 22'h000000, 1'b0, 2'b00},
        '{36'h0_0000_0000, 26'h0000000, 2'b00, 1'b1, 2'b00, 1'b1, 1'b0, 22'h000777, 1'b0, 2'b00},
        '{36'h0_0800_0000, 26'h0000333, 2'b01, 1'b1, 2'b10, 1'b1, 1'b1, 22'h000888, 1'b1, 2'b10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [25:0] req_vpn = '0;
    logic [1:0]  req_kind = '0;
    logic [35:0] table_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [35:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_ready;
    logic [63:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic        res_fault;
    logic [1:0]  res_cause;
    logic [25:0] res_vpn;
    logic [21:0] res_ppn;
    logic [1:0]  res_rights;
    logic        res_dirty;
    logic        res_ref;
    logic        busy;

    int total = 0;
    int fails = 0;
    int nreads = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (mem_req_valid && mem_req_ready) nreads <= nreads + 1;

    ptw_walker i_ptw_walker (
        .clk, .rst_n, .req_valid, .req_ready, .req_vpn, .req_kind, .table_base,
        .mem_req_valid, .mem_req_ready, .mem_req_addr,
        .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data,
        .res_valid, .res_ready, .res_fault, .res_cause, .res_vpn, .res_ppn,
        .res_rights, .res_dirty, .res_ref, .busy
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Entry word per R6; spare bits filled with ones to show they are ignored
    function automatic logic [63:0] build_entry(input vec_t v);
        logic [63:0] e;
        e = {34'h3_FFFF_FFFF, v.ppn, 3'b111, v.r, v.d, v.rights, v.v};
        return e;
    endfunction

    task automatic run_walk(input vec_t v, input int rdy_delay, input int rsp_delay,
                            input int hold, input bit poke);
        logic [35:0] exp_addr;
        int          reads0;
        logic [63:0] snap;
        exp_addr = v.base + 36'({v.vpn, 3'b000});
        @(negedge clk);
        chk(req_ready == 1'b1, "R4 idle req_ready", 64'(req_ready), 64'd1);
        req_valid  = 1'b1;
        req_vpn    = v.vpn;
        req_kind   = v.kind;
        table_base = v.base;
        reads0     = nreads;
        @(negedge clk);
        req_valid = poke;
        if (poke) begin
            req_vpn    = ~v.vpn;
            table_base = ~v.base;
        end
        chk(busy == 1'b1, "R4 busy after accept", 64'(busy), 64'd1);
        for (int i = 0; i < rdy_delay; i++) begin
            chk(mem_req_valid == 1'b1 && mem_req_addr == exp_addr, "R3 read held while stalled",
                64'(mem_req_addr), 64'(exp_addr));
            @(negedge clk);
        end
        chk(mem_req_valid == 1'b1, "R3 read valid", 64'(mem_req_valid), 64'd1);
        chk(mem_req_addr == exp_addr, "R2 entry address", 64'(mem_req_addr), 64'(exp_addr));
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(mem_req_valid == 1'b0 && nreads == reads0 + 1, "R3 one read",
            64'(nreads - reads0), 64'd1);
        for (int i = 0; i < rsp_delay; i++) @(negedge clk);
        chk(mem_rsp_ready == 1'b1, "R3 awaiting response", 64'(mem_rsp_ready), 64'd1);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = build_entry(v);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        @(negedge clk);
        chk(res_valid == 1'b1, "R6 result valid", 64'(res_valid), 64'd1);
        chk(res_fault == v.fault && res_cause == v.cause,
            v.cause == 2'b01 ? "R5 not-present fault" : (v.cause == 2'b10 ? "R7 R8 protection fault" : "R7 allowed access"),
            64'({res_fault, res_cause}), 64'({v.fault, v.cause}));
        chk(res_vpn == v.vpn, "R10 result vpn", 64'(res_vpn), 64'(v.vpn));
        if (v.fault) begin
            chk(res_ppn == '0 && res_rights == 2'b00 && !res_dirty && !res_ref, "R10 fault fields zero",
                64'({res_ppn, res_rights, res_dirty, res_ref}), 64'd0);
        end else begin
            chk({res_ppn, res_rights, res_dirty, res_ref} == {v.ppn, v.rights, v.d, v.r}, "R6 refill fields",
                64'({res_ppn, res_rights, res_dirty, res_ref}), 64'({v.ppn, v.rights, v.d, v.r}));
        end
        if (poke) chk(req_ready == 1'b0, "R4 busy request ignored", 64'(req_ready), 64'd0);
        snap = 64'({res_fault, res_cause, res_vpn, res_ppn, res_rights, res_dirty, res_ref});
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(res_valid == 1'b1 && 64'({res_fault, res_cause, res_vpn, res_ppn, res_rights, res_dirty, res_ref}) == snap,
                "R9 result held", 64'({res_fault, res_cause, res_vpn, res_ppn, res_rights, res_dirty, res_ref}), snap);
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        req_valid = 1'b0;
        chk(busy == 1'b0 && res_valid == 1'b0, "R4 released after consume", 64'({busy, res_valid}), 64'd0);
        chk(nreads == reads0 + 1, "R3 single read per walk", 64'(nreads - reads0), 64'd1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL R3 watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0 && req_ready == 1'b1 && mem_req_valid == 1'b0 && mem_rsp_ready == 1'b0 && res_valid == 1'b0,
            "R1 reset state", 64'({busy, req_ready, mem_req_valid, mem_rsp_ready, res_valid}), 64'b01000);

        // Directed: stalls on every handshake plus a request presented while busy
        run_walk(VECS[0], 3, 2, 4, 1'b1);
        // Follow-up walk shows the ignored request left no trace (R4)
        run_walk(VECS[1], 0, 0, 0, 1'b0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            run_walk(VECS[k], k % 3, (k + 1) % 2, k % 2, 1'b0);
        end

        // R1: reset in the middle of a walk
        @(negedge clk);
        req_valid  = 1'b1;
        req_vpn    = 26'h0000042;
        req_kind   = 2'b00;
        table_base = 36'h0_0000_1000;
        @(negedge clk);
        req_valid = 1'b0;
        rst_n     = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(busy == 1'b0 && req_ready == 1'b1 && mem_req_valid == 1'b0 && res_valid == 1'b0,
            "R1 reset mid-walk", 64'({busy, req_ready, mem_req_valid, res_valid}), 64'b0100);
        @(negedge clk);
        run_walk(VECS[11], 1, 1, 1, 1'b0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule